// File: doc/BRIEF.md
# SDRAM Command Bus Protocol Monitor

This block sits passively beside an SDRAM command bus and watches every rising clock edge. It turns the sampled strobes into a command, keeps its own copy of each bank's state (idle, open, or closing on its own after a burst with automatic precharge) and reports any protocol violation one cycle later. The report is a single-cycle error flag together with a small code that names the violation class.

All timing limits are given as cycle counts through parameters: burst length, precharge period, the quiet window after a mode register write, and the longest time a row may stay open. When several rules are broken by the same command, a fixed priority picks the code. A command that raises an error is treated as not accepted and leaves the bank model unchanged. The monitor also follows the data mask pin. Write data is masked in the cycle the mask is sampled. For read data, the mask takes effect two edges later, so the monitor can mark the read beats that must not carry data.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After reset every bank reads idle (code 0 in its two-bit state field), `errValid` is low, `errCode` is 0 and `rdHiZ` is low.
- R2: With CS# low, {RAS#,CAS#,WE#} decodes as 111 no-op, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 001 refresh, 000 mode register write. CS# high is a deselect, whatever the other strobes are. An activate sets the bank state to 1 (open). A precharge closes the addressed bank when address bit 10 is low, and closes all banks when that bit is high.
- R3: When CKE was low at the previous edge and is still low, the cycle is frozen: it is ignored and reports nothing. When CKE was low at the previous edge and is high now, any command other than no-op or deselect gives code 1.
- R4: During the T_MRD-1 edges that follow an accepted mode register write, any command other than no-op or deselect gives code 2.
- R5: A mode register write, an auto refresh, or a self-refresh entry (refresh with CKE falling) while any bank is not idle gives code 3.
- R6: A read or write with address bit 10 high, sampled at edge 0, puts that bank in state 2. The state stays 2 up to and including the cycle after edge BURST_LEN+T_RP-2, and the bank is idle from the following edge. A read, write or activate to the bank at edges 1 to BURST_LEN+T_RP-1 gives code 4. An activate at edge BURST_LEN+T_RP is accepted.
- R7: A read or write to an idle bank, or an activate to an open bank, gives code 5.
- R8: A bank activated at edge 0 and still open at edge T_RAS_MAX+1 gives code 6, once. A bank precharged at edge T_RAS_MAX or earlier is not flagged.
- R9: A command that raises an error does not change any bank state. If one command breaks several rules, the lowest code (1 to 5) is reported, and any command error is reported in place of code 6.
- R10: `wrMask` follows DQM in the same cycle. `rdHiZ` is high for exactly the clock period that ends at the second edge after DQM was sampled high, whatever the CS# level.
- R11: `errValid` and `errCode` change only on the edge after the offending sample and hold for one cycle. A following legal cycle returns them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable as seen on the bus |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask |
| ba | input | BANK_W | Bank address |
| addr | input | ADDR_W | Multiplexed address; bit AP_BIT is the auto/all flag |
| errValid | output | 1 | One-cycle violation pulse |
| errCode | output | 3 | Violation class, 0 when none |
| bankState | output | 2*NUM_BANKS | Per-bank state: 0 idle, 1 open, 2 auto-precharging |
| wrMask | output | 1 | Current write beat is masked |
| rdHiZ | output | 1 | Read beat captured at the next edge must be high impedance |

## Verification
The hardest case to reach from the ports is the edge of the auto-precharge lockout. A lockout error, a state readout that has just gone idle and an activate that is accepted all fall within two adjacent edges. The bench issues the auto-precharged read and then places an activate exactly on the last locked edge and another on the first free edge. The row-open limit needs a long wait. The bench overrides it to a small count and holds a bank open one edge short of the limit and one edge past it.

// File: rtl/sdmon_pkg.sv
`timescale 1ns/1ps
package sdmon_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_BST, CMD_PRE, CMD_REF, CMD_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_CKE    = 3'd1,
    ERR_MRD    = 3'd2,
    ERR_BUSY   = 3'd3,
    ERR_APLOCK = 3'd4,
    ERR_STATE  = 3'd5,
    ERR_RASMAX = 3'd6
  } err_e;

  localparam logic [1:0] BS_IDLE    = 2'd0;
  localparam logic [1:0] BS_ACTIVE  = 2'd1;
  localparam logic [1:0] BS_AUTOPRE = 2'd2;

  // control -> timer strobes
  typedef struct packed {
    logic                 mrs;
    logic [NUM_BANKS-1:0] apStart;
    logic [NUM_BANKS-1:0] openVec;
  } strobe_t;
endpackage

// File: rtl/sdmon_timers.sv
`timescale 1ns/1ps
module sdmon_timers
  import sdmon_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_RAS_MAX = 13334
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dqm,
  input  strobe_t              strb,
  output logic [NUM_BANKS-1:0] apBusy,
  output logic                 mrdBusy,
  output logic                 rasExpire,
  output logic                 rdHiZ
);
  localparam int AP_LOAD = BURST_LEN + T_RP - 1;
  localparam int AP_W    = $clog2(AP_LOAD + 1);
  localparam int MRD_W   = $clog2(T_MRD + 1);
  localparam int RAS_W   = $clog2(T_RAS_MAX + 2);

  logic [NUM_BANKS-1:0] rasHit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [AP_W-1:0]  apCnt;
    logic [RAS_W-1:0] rasCnt;

    always_ff @(posedge clk) begin
      if (!rstN)                apCnt <= '0;
      else if (strb.apStart[b]) apCnt <= AP_W'(AP_LOAD);
      else if (apCnt != '0)     apCnt <= apCnt - 1'b1;
    end
    assign apBusy[b] = (apCnt != '0);

    always_ff @(posedge clk) begin
      if (!rstN || !strb.openVec[b])         rasCnt <= '0;
      else if (rasCnt <= RAS_W'(T_RAS_MAX))  rasCnt <= rasCnt + 1'b1;
    end
    assign rasHit[b] = strb.openVec[b] && (rasCnt == RAS_W'(T_RAS_MAX));

    p_ap_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
      strb.apStart[b] |=> apBusy[b]);
  end

  assign rasExpire = |rasHit;

  logic [MRD_W-1:0] mrdCnt;
  always_ff @(posedge clk) begin
    if (!rstN)             mrdCnt <= '0;
    else if (strb.mrs)     mrdCnt <= MRD_W'(T_MRD - 1);
    else if (mrdCnt != '0) mrdCnt <= mrdCnt - 1'b1;
  end
  assign mrdBusy = (mrdCnt != '0);

  if (T_MRD >= 2) begin : g_mrd_chk
    p_mrd_window_r4: assert property (@(posedge clk) disable iff (!rstN)
      strb.mrs |=> mrdBusy);
  end

  // read mask path: two stages
  logic dqmD1, dqmD2;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dqmD1 <= 1'b0;
      dqmD2 <= 1'b0;
    end else begin
      dqmD1 <= dqm;
      dqmD2 <= dqmD1;
    end
  end
  assign rdHiZ = dqmD2;

  p_rdhiz_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdHiZ) |-> $past(dqm, 2));
endmodule

// File: rtl/sdmon_ctrl.sv
`timescale 1ns/1ps
module sdmon_ctrl
  import sdmon_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cke,
  input  logic                   csN,
  input  logic                   rasN,
  input  logic                   casN,
  input  logic                   weN,
  input  logic [BANK_W-1:0]      ba,
  input  logic                   apFlag,
  input  logic [NUM_BANKS-1:0]   apBusy,
  input  logic                   mrdBusy,
  input  logic                   rasExpire,
  output strobe_t                strb,
  output logic                   errValid,
  output logic [2:0]             errCode,
  output logic [2*NUM_BANKS-1:0] bankState
);
  logic                 ckePrev;
  logic [NUM_BANKS-1:0] openVec, openNext, apStart;
  cmd_e                 cmd;
  err_e                 cmdErr, errCodeQ;
  logic                 isCmd, allIdle, go;

  always_comb begin
    if (csN) cmd = CMD_NOP;
    else begin
      unique case ({rasN, casN, weN})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_MRS;
      endcase
    end
  end

  assign isCmd   = (cmd != CMD_NOP);
  assign allIdle = (openVec == '0) && (apBusy == '0);

  // fixed priority: lower code wins
  always_comb begin
    cmdErr = ERR_NONE;
    if (!ckePrev) begin
      if (cke && isCmd) cmdErr = ERR_CKE;
    end else if (isCmd && mrdBusy) begin
      cmdErr = ERR_MRD;
    end else begin
      unique case (cmd)
        CMD_MRS, CMD_REF: if (!allIdle) cmdErr = ERR_BUSY;
        CMD_ACT: begin
          if (apBusy[ba])       cmdErr = ERR_APLOCK;
          else if (openVec[ba]) cmdErr = ERR_STATE;
        end
        CMD_RD, CMD_WR: begin
          if (apBusy[ba])        cmdErr = ERR_APLOCK;
          else if (!openVec[ba]) cmdErr = ERR_STATE;
        end
        default: ;
      endcase
    end
  end

  assign go = ckePrev && isCmd && (cmdErr == ERR_NONE);

  always_comb begin
    openNext = openVec;
    apStart  = '0;
    if (go) begin
      unique case (cmd)
        CMD_ACT: openNext[ba] = 1'b1;
        CMD_RD, CMD_WR: if (apFlag) begin
          openNext[ba] = 1'b0;
          apStart[ba]  = 1'b1;
        end
        CMD_PRE: if (apFlag) openNext = '0;
                 else        openNext[ba] = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckePrev  <= 1'b0;
      openVec  <= '0;
      errValid <= 1'b0;
      errCodeQ <= ERR_NONE;
    end else begin
      ckePrev  <= cke;
      openVec  <= openNext;
      errValid <= (cmdErr != ERR_NONE) || rasExpire;
      errCodeQ <= (cmdErr != ERR_NONE) ? cmdErr :
                  (rasExpire ? ERR_RASMAX : ERR_NONE);
    end
  end

  assign errCode      = errCodeQ;
  assign strb.mrs     = go && (cmd == CMD_MRS);
  assign strb.apStart = apStart;
  assign strb.openVec = openVec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_state
    assign bankState[2*b +: 2] = apBusy[b]  ? BS_AUTOPRE :
                                 openVec[b] ? BS_ACTIVE  : BS_IDLE;
  end

  p_open_ap_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    (openVec & apBusy) == '0);

  p_frozen_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ckePrev && !cke) |=> (errCodeQ == ERR_NONE || errCodeQ == ERR_RASMAX));
endmodule

// File: rtl/sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sdram_cmd_monitor
  import sdmon_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_RAS_MAX = 13334
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cke,
  input  logic                   csN,
  input  logic                   rasN,
  input  logic                   casN,
  input  logic                   weN,
  input  logic                   dqm,
  input  logic [BANK_W-1:0]      ba,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   errValid,
  output logic [2:0]             errCode,
  output logic [2*NUM_BANKS-1:0] bankState,
  output logic                   wrMask,
  output logic                   rdHiZ
);
  strobe_t              strb;
  logic [NUM_BANKS-1:0] apBusy;
  logic                 mrdBusy, rasExpire;
  logic                 unusedAddrBits;

  assign unusedAddrBits = ^addr;
  assign wrMask         = dqm;

  sdmon_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .apFlag(addr[AP_BIT]), .apBusy(apBusy),
    .mrdBusy(mrdBusy), .rasExpire(rasExpire), .strb(strb),
    .errValid(errValid), .errCode(errCode), .bankState(bankState)
  );

  sdmon_timers #(
    .BURST_LEN(BURST_LEN), .T_RP(T_RP), .T_MRD(T_MRD), .T_RAS_MAX(T_RAS_MAX)
  ) i_timers (
    .clk(clk), .rstN(rstN), .dqm(dqm), .strb(strb), .apBusy(apBusy),
    .mrdBusy(mrdBusy), .rasExpire(rasExpire), .rdHiZ(rdHiZ)
  );
endmodule

// File: tb/test_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module test_sdram_cmd_monitor;
  localparam int RAS_LIM = 20;
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                         C_WR = 3'b100, C_PRE = 3'b010, C_REF = 3'b001,
                         C_MRS = 3'b000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, dqm = 1'b0;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic        errValid, wrMask, rdHiZ;
  logic [2:0]  errCode;
  logic [7:0]  bankState;
  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  sdram_cmd_monitor #(.T_RAS_MAX(RAS_LIM)) i_sdram_cmd_monitor (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .dqm(dqm), .ba(ba), .addr(addr), .errValid(errValid),
    .errCode(errCode), .bankState(bankState), .wrMask(wrMask), .rdHiZ(rdHiZ)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkErr(input string req, input int code);
    chk({req, " errValid"}, int'(errValid), (code != 0) ? 1 : 0);
    chk({req, " errCode"}, int'(errCode), code);
  endtask

  function automatic int bs(input int b);
    return int'(bankState[2*b +: 2]);
  endfunction

  task automatic drive(input logic cs, input logic [2:0] rcw, input int bank,
                       input logic a10, input logic ck, input logic dq);
    @(negedge clk);
    csN = cs; {rasN, casN, weN} = rcw; ba = bank[1:0];
    addr = '0; addr[10] = a10; cke = ck; dqm = dq;
    @(posedge clk); #1;
  endtask

  task automatic cmd(input logic [2:0] rcw, input int bank, input logic a10);
    drive(1'b0, rcw, bank, a10, 1'b1, 1'b0);
  endtask

  task automatic nop();
    cmd(C_NOP, 0, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 state", int'(bankState), 0);
    chkErr("R1", 0);
    chk("R1 rdHiZ", int'(rdHiZ), 0);
    nop();
  endtask

  task automatic t_decode();
    cmd(C_ACT, 1, 1'b0); chkErr("R2 act1", 0); chk("R2 bank1 open", bs(1), 1);
    cmd(C_ACT, 2, 1'b0); chk("R2 bank2 open", bs(2), 1);
    cmd(C_PRE, 1, 1'b0); chk("R2 bank1 closed", bs(1), 0); chk("R2 bank2 kept", bs(2), 1);
    drive(1'b1, C_MRS, 2, 1'b0, 1'b1, 1'b0);
    chkErr("R2 deselect", 0); chk("R2 deselect no effect", bs(2), 1);
    cmd(C_PRE, 0, 1'b1); chk("R2 precharge all", int'(bankState), 0);
  endtask

  task automatic t_illegal_state();
    cmd(C_RD, 0, 1'b0); chkErr("R7 read idle", 5); chk("R9 no effect", bs(0), 0);
    nop(); chkErr("R11 pulse clears", 0);
    cmd(C_ACT, 0, 1'b0); chkErr("R7 act", 0);
    cmd(C_ACT, 0, 1'b0); chkErr("R7 act open", 5); chk("R9 still open", bs(0), 1);
    cmd(C_WR, 0, 1'b0); chkErr("R7 write open", 0);
    cmd(C_PRE, 0, 1'b1);
  endtask

  task automatic t_all_idle();
    cmd(C_ACT, 3, 1'b0);
    cmd(C_REF, 0, 1'b0); chkErr("R5 refresh busy", 3);
    cmd(C_MRS, 0, 1'b0); chkErr("R5 mrs busy", 3);
    drive(1'b0, C_REF, 0, 1'b0, 1'b0, 1'b0); chkErr("R5 self refresh busy", 3);
    chk("R9 bank3 kept", bs(3), 1);
    drive(1'b0, C_NOP, 0, 1'b0, 1'b1, 1'b0); chkErr("R3 exit nop", 0);
    cmd(C_PRE, 0, 1'b1);
    cmd(C_REF, 0, 1'b0); chkErr("R5 refresh idle", 0);
  endtask

  task automatic t_mrd();
    nop();
    cmd(C_MRS, 0, 1'b0); chkErr("R4 mrs", 0);
    cmd(C_ACT, 0, 1'b0); chkErr("R4 window", 2); chk("R9 no act", bs(0), 0);
    cmd(C_ACT, 0, 1'b0); chkErr("R4 after window", 0); chk("R4 open", bs(0), 1);
    cmd(C_PRE, 0, 1'b1);
    cmd(C_MRS, 0, 1'b0);
    cmd(C_RD, 1, 1'b0); chkErr("R9 priority mrd over state", 2);
    nop();
  endtask

  task automatic t_cke();
    drive(1'b0, C_NOP, 0, 1'b0, 1'b0, 1'b0); chkErr("R3 enter", 0);
    drive(1'b0, C_ACT, 0, 1'b0, 1'b0, 1'b0); chkErr("R3 frozen", 0);
    chk("R3 frozen no effect", bs(0), 0);
    drive(1'b0, C_ACT, 0, 1'b0, 1'b1, 1'b0); chkErr("R3 exit cmd", 1);
    chk("R3 exit no effect", bs(0), 0);
    cmd(C_ACT, 0, 1'b0); chkErr("R3 after exit", 0); chk("R3 open", bs(0), 1);
    cmd(C_PRE, 0, 1'b1);
  endtask

  task automatic t_autopre();
    cmd(C_ACT, 2, 1'b0);
    cmd(C_RD, 2, 1'b1); chkErr("R6 ap read", 0); chk("R6 state 2", bs(2), 2);
    cmd(C_RD, 2, 1'b0); chkErr("R6 read locked", 4);
    for (int i = 2; i <= 5; i++) nop();
    chk("R6 still 2", bs(2), 2);
    cmd(C_ACT, 2, 1'b0); chkErr("R6 act last locked", 4); chk("R6 idle", bs(2), 0);
    cmd(C_ACT, 2, 1'b0); chkErr("R6 act free", 0); chk("R6 reopened", bs(2), 1);
    cmd(C_PRE, 0, 1'b1);
  endtask

  task automatic t_ras_max();
    cmd(C_ACT, 0, 1'b0);
    for (int i = 1; i < RAS_LIM; i++) nop();
    cmd(C_PRE, 0, 1'b0); chkErr("R8 closed in time", 0);
    cmd(C_ACT, 0, 1'b0);
    for (int i = 1; i <= RAS_LIM; i++) nop();
    chkErr("R8 at limit", 0);
    nop(); chkErr("R8 over limit", 6);
    nop(); chkErr("R8 once", 0);
    cmd(C_PRE, 0, 1'b1);
  endtask

  task automatic t_dqm();
    @(negedge clk);
    csN = 1'b1; {rasN, casN, weN} = C_NOP; dqm = 1'b1; cke = 1'b1;
    #1 chk("R10 wrMask same cycle", int'(wrMask), 1);
    @(posedge clk); #1;
    chk("R10 rdHiZ not yet", int'(rdHiZ), 0);
    drive(1'b1, C_NOP, 0, 1'b0, 1'b1, 1'b0);
    chk("R10 rdHiZ second edge", int'(rdHiZ), 1);
    chk("R10 wrMask low", int'(wrMask), 0);
    nop(); chk("R10 rdHiZ one period", int'(rdHiZ), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_decode();
    t_illegal_state();
    t_all_idle();
    t_mrd();
    t_cke();
    t_autopre();
    t_ras_max();
    t_dqm();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule